// File: doc/BRIEF.md
# Single-Wire Battery Gauge Host Controller

This block is the host side of a link to a battery fuel gauge that shares one open-drain wire. A command byte arrives on parallel inputs together with an optional write byte. The host turns it into pulses on the wire. Bit 7 of the command picks the direction, and bits 6:0 give the location inside the gauge. A write transfer sends the write byte as a second frame. A read transfer runs a second frame in which the host opens each bit slot with a short pulse and then lets the gauge hold the line low (a 0) or leave it high (a 1). The host samples the line in the middle of the slot.

Every frame holds ten slots: a start slot, eight data slots with the least significant bit first, and a stop slot. A slot lasts a programmable number of system clocks. Within a slot the host pulls the line low for a fraction of the slot: a quarter for a 1, three quarters for a 0, and half for a start. It leaves the line released for the whole stop slot. A second, two-wire bus engine can share the pins. This engine has priority whenever it is enabled, and the other engine is granted the pins only when this one is disabled and idle.

Top module: `swbm_host`

## Requirements
- R1: After reset `busy`, `done`, `err` and `line_oe` are 0 and `rdata` is 0x00. While idle, `line_oe` stays 0.
- R2: Each frame is one start slot (line low for floor(L/2) clocks), then eight data slots LSB first, then a stop slot with the line released. A 1 drives low for floor(L/4) clocks and a 0 for floor(L/4)+floor(L/2) clocks, counted from the start of the slot.
- R3: The first frame carries `cmd`. If `cmd[7]`=0 the second frame carries `wdata`. If `cmd[7]`=1 the second frame is a read frame.
- R4: In each data slot of a read frame the host drives low for floor(L/4) clocks. It samples the synchronised line when the slot position equals floor(L/2). A released line gives 1 and a low line gives 0. The i-th slot gives `rdata[i]`.
- R5: The slot length L is `cfg_slot` clocks, with values below 8 treated as 8. L is captured when a transfer is accepted, and later changes of `cfg_slot` do not affect a running transfer.
- R6: `busy` is 1 from the cycle after acceptance until `done`. `done` is a one-cycle pulse exactly 20·L cycles after the accepting edge, with `busy` back at 0 in that cycle.
- R7: `rdata` changes only in the `done` cycle of a read transfer. Write transfers leave it unchanged.
- R8: A `start` while busy is ignored, and the wire sequence and timing of the running transfer are unchanged. It sets `err`, which stays 1 until reset.
- R9: `start` with `sw_en`=0 starts nothing and does not set `err`.
- R10: `tw_grant` equals `tw_en & ~sw_en & ~busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_en | input | 1 | Enables this single-wire engine |
| tw_en | input | 1 | Enable request from the two-wire bus engine |
| tw_grant | output | 1 | Pins granted to the two-wire engine |
| cfg_slot | input | SLOT_W | Slot length in clocks (floor 8) |
| start | input | 1 | Launch a transfer |
| cmd | input | 8 | Command: bit 7 read/write, bits 6:0 location |
| wdata | input | 8 | Byte sent on a write transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 8 | Byte returned by the last read |
| err | output | 1 | Sticky flag: start received while busy |
| line_in | input | 1 | Sensed level of the wire |
| line_oe | output | 1 | Open-drain pull-low enable |

## Verification
The bench builds the block with its default parameters: an 8-bit slot field, a floor of 8 clocks and a two-stage line synchroniser. With an 8-clock slot a full transfer takes 160 cycles, so all 256 command values, reads and writes alike, can be swept. Each transfer uses its own write byte and its own gauge reply. Further runs cover slot settings below the floor, odd slot lengths, a slot setting changed mid-transfer, a start while busy, a start while disabled, and the grant truth table.

// File: rtl/swbm_pkg.sv
package swbm_pkg;
    localparam int unsigned FRAME_BITS      = 8;
    localparam int unsigned SLOTS_PER_FRAME = FRAME_BITS + 2;
    localparam int unsigned IDX_W           = $clog2(SLOTS_PER_FRAME);
    localparam int unsigned DIDX_W          = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FRAME0,
        PH_FRAME1
    } phase_e;

    typedef enum logic [2:0] {
        SK_NONE,
        SK_START,
        SK_ONE,
        SK_ZERO,
        SK_READ,
        SK_STOP
    } slot_e;
endpackage

// File: rtl/swbm_slot_timer.sv
module swbm_slot_timer #(
    parameter int unsigned SLOT_W   = 8,
    parameter int unsigned MIN_SLOT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [SLOT_W-1:0] cfg_len,
    output logic [SLOT_W-1:0] pos,
    output logic [SLOT_W-1:0] q_len,
    output logic [SLOT_W-1:0] h_len,
    output logic [SLOT_W-1:0] t_len,
    output logic              slot_last,
    output logic              mid
);
    localparam logic [SLOT_W-1:0] MIN_L = SLOT_W'(MIN_SLOT);

    typedef struct packed {
        logic [SLOT_W-1:0] pos;
        logic [SLOT_W-1:0] len;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.pos = '0;
            tmr_d.len = (cfg_len < MIN_L) ? MIN_L : cfg_len;
        end else if (run) begin
            tmr_d.pos = (tmr_q.pos == tmr_q.len - SLOT_W'(1)) ? '0 : tmr_q.pos + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.pos <= '0;
            tmr_q.len <= MIN_L;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign pos       = tmr_q.pos;
    assign q_len     = tmr_q.len >> 2;
    assign h_len     = tmr_q.len >> 1;
    assign t_len     = q_len + h_len;
    assign slot_last = run && (tmr_q.pos == tmr_q.len - SLOT_W'(1));
    assign mid       = run && (tmr_q.pos == h_len);

    // R5: slot length never drops below the floor
    p_len_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.len >= MIN_L);

    // R5: a running transfer keeps its captured length
    p_len_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> $stable(tmr_q.len));

    // R6: slot position stays inside the slot
    p_pos_in_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.pos < tmr_q.len);
endmodule

// File: rtl/swbm_line_sync.sv
module swbm_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = din;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/swbm_frame_seq.sv
module swbm_frame_seq
    import swbm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic [FRAME_BITS-1:0] cmd_in,
    input  logic [FRAME_BITS-1:0] wdata_in,
    input  logic                  slot_last,
    input  logic                  mid,
    input  logic                  line_s,
    output logic                  launch,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    output logic [FRAME_BITS-1:0] rdata,
    output slot_e                 kind
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS_PER_FRAME - 1);

    typedef struct packed {
        phase_e                phase;
        logic [IDX_W-1:0]      bidx;
        logic [FRAME_BITS-1:0] cmd;
        logic [FRAME_BITS-1:0] wbyte;
        logic [FRAME_BITS-1:0] rx;
        logic [FRAME_BITS-1:0] rdata;
        logic                  done;
        logic                  err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [DIDX_W-1:0]     didx;
    logic [FRAME_BITS-1:0] cur_byte;
    logic                  is_read;

    assign didx     = DIDX_W'(seq_q.bidx - IDX_W'(1));
    assign is_read  = seq_q.cmd[FRAME_BITS-1];
    assign cur_byte = (seq_q.phase == PH_FRAME0) ? seq_q.cmd : seq_q.wbyte;

    always_comb begin
        if (seq_q.phase == PH_IDLE)                     kind = SK_NONE;
        else if (seq_q.bidx == '0)                      kind = SK_START;
        else if (seq_q.bidx == LAST_IDX)                kind = SK_STOP;
        else if (seq_q.phase == PH_FRAME1 && is_read)   kind = SK_READ;
        else if (cur_byte[didx])                        kind = SK_ONE;
        else                                            kind = SK_ZERO;
    end

    assign launch = req && (seq_q.phase == PH_IDLE);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (req && seq_q.phase != PH_IDLE) seq_d.err = 1'b1;
        if (launch) begin
            seq_d.phase = PH_FRAME0;
            seq_d.bidx  = '0;
            seq_d.cmd   = cmd_in;
            seq_d.wbyte = wdata_in;
        end else if (seq_q.phase != PH_IDLE) begin
            if (mid && kind == SK_READ) seq_d.rx[didx] = line_s;
            if (slot_last) begin
                if (seq_q.bidx == LAST_IDX) begin
                    seq_d.bidx = '0;
                    if (seq_q.phase == PH_FRAME0) begin
                        seq_d.phase = PH_FRAME1;
                    end else begin
                        seq_d.phase = PH_IDLE;
                        seq_d.done  = 1'b1;
                        if (is_read) seq_d.rdata = seq_q.rx;
                    end
                end else begin
                    seq_d.bidx = seq_q.bidx + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= PH_IDLE;
            seq_q.bidx  <= '0;
            seq_q.cmd   <= '0;
            seq_q.wbyte <= '0;
            seq_q.rx    <= '0;
            seq_q.rdata <= '0;
            seq_q.done  <= 1'b0;
            seq_q.err   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy  = (seq_q.phase != PH_IDLE);
    assign done  = seq_q.done;
    assign err   = seq_q.err;
    assign rdata = seq_q.rdata;

    // R6: done lasts exactly one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done marks the end of a busy period
    p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R7: read data moves only at the end of a read
    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!done || !is_read) |-> $stable(seq_q.rdata));

    // R8: the error flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R2: slot index stays inside a frame
    p_bidx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.bidx <= LAST_IDX);
endmodule

// File: rtl/swbm_host.sv
module swbm_host
    import swbm_pkg::*;
#(
    parameter int unsigned SLOT_W      = 8,
    parameter int unsigned MIN_SLOT    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sw_en,
    input  logic                  tw_en,
    output logic                  tw_grant,
    input  logic [SLOT_W-1:0]     cfg_slot,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] cmd,
    input  logic [FRAME_BITS-1:0] wdata,
    output logic                  busy,
    output logic                  done,
    output logic [FRAME_BITS-1:0] rdata,
    output logic                  err,
    input  logic                  line_in,
    output logic                  line_oe
);
    logic [SLOT_W-1:0] pos, q_len, h_len, t_len;
    logic              slot_last, mid, line_s, launch;
    slot_e             kind;

    swbm_slot_timer #(
        .SLOT_W   (SLOT_W),
        .MIN_SLOT (MIN_SLOT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (launch),
        .run       (busy),
        .cfg_len   (cfg_slot),
        .pos       (pos),
        .q_len     (q_len),
        .h_len     (h_len),
        .t_len     (t_len),
        .slot_last (slot_last),
        .mid       (mid)
    );

    swbm_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_in),
        .dout  (line_s)
    );

    swbm_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (start && sw_en),
        .cmd_in    (cmd),
        .wdata_in  (wdata),
        .slot_last (slot_last),
        .mid       (mid),
        .line_s    (line_s),
        .launch    (launch),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rdata     (rdata),
        .kind      (kind)
    );

    always_comb begin
        case (kind)
            SK_START:        line_oe = (pos < h_len);
            SK_ONE, SK_READ: line_oe = (pos < q_len);
            SK_ZERO:         line_oe = (pos < t_len);
            default:         line_oe = 1'b0;
        endcase
    end

    assign tw_grant = tw_en && !sw_en && !busy;

    // R1: no pull while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_oe);

    // R2: stop slot leaves the line released
    p_stop_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SK_STOP) |-> !line_oe);

    // R2: every slot starts with a pull except the stop slot
    p_slot_opens_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pos == '0 && kind != SK_STOP) |-> line_oe);

    // R10: the companion engine is held off while this one runs
    p_grant_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tw_grant);
endmodule

// File: tb/swbm_host_test.sv
module swbm_host_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_en = 1'b1;
    logic       tw_en = 1'b1;
    logic       tw_grant;
    logic [7:0] cfg_slot = 8'd8;
    logic       start = 1'b0;
    logic [7:0] cmd = '0;
    logic [7:0] wdata = '0;
    logic       busy, done, err, line_oe, line_in;
    logic [7:0] rdata;

    logic       pull = 1'b0;
    logic       prev_oe = 1'b0;
    logic       gauge_on = 1'b0;
    logic [7:0] reply = '0;
    int         lat_len = 8;
    int         pulse_idx = 0;
    int         pull_cnt = 0;
    int         run_len = 0;
    int         nsym = 0;
    int         sym [0:31];
    int         errors = 0;
    int         checks = 0;
    logic [7:0] exp_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line_in = ~(line_oe | pull);

    swbm_host uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_en    (sw_en),
        .tw_en    (tw_en),
        .tw_grant (tw_grant),
        .cfg_slot (cfg_slot),
        .start    (start),
        .cmd      (cmd),
        .wdata    (wdata),
        .busy     (busy),
        .done     (done),
        .rdata    (rdata),
        .err      (err),
        .line_in  (line_in),
        .line_oe  (line_oe)
    );

    // wire decoder and gauge model; symbols: 0 zero, 1 one, 2 start
    always @(negedge clk) begin
        logic w_now;
        int   ql, hl, tl;
        ql = lat_len >> 2;
        hl = lat_len >> 1;
        tl = ql + hl;
        if (start && !busy) begin
            nsym = 0;
            pulse_idx = 0;
            pull_cnt = 0;
        end
        if (line_oe && !prev_oe) begin
            pulse_idx++;
            if (gauge_on && pulse_idx >= 11 && pulse_idx <= 18 && !reply[pulse_idx-11])
                pull_cnt = tl;
        end
        if (pull_cnt > 0) begin
            pull = 1'b1;
            pull_cnt--;
        end else begin
            pull = 1'b0;
        end
        prev_oe = line_oe;
        w_now = ~(line_oe | pull);
        if (!w_now) begin
            run_len++;
        end else if (run_len > 0) begin
            if (nsym < 32) begin
                if (run_len < (ql + hl) / 2)      sym[nsym] = 1;
                else if (run_len < (hl + tl) / 2) sym[nsym] = 2;
                else                              sym[nsym] = 0;
            end
            nsym++;
            run_len = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_txn(input logic [7:0] c, input logic [7:0] w, input logic [7:0] r,
                           input int cfg_v, input int cfg_mid, input bit inject);
        int n;
        int lexp;
        int exp_sym [0:17];
        bit sym_ok;
        int bad_i;
        lexp = (cfg_v < 8) ? 8 : cfg_v;
        @(posedge clk); #1;
        reply    = r;
        gauge_on = c[7];
        lat_len  = lexp;
        cfg_slot = 8'(cfg_v);
        cmd      = c;
        wdata    = w;
        start    = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        check(busy == 1'b1, "R6 busy after accept", int'(busy), 1);
        check(tw_grant == 1'b0, "R10 grant while busy", int'(tw_grant), 0);
        n = 0;
        while (!done && n < 4000) begin
            @(posedge clk); n++; #1;
            if (n == 3) cfg_slot = 8'(cfg_mid);
            if (inject && n == 5) begin start = 1'b1; cmd = ~c; wdata = ~w; end
            if (inject && n == 6) start = 1'b0;
        end
        check(n == 20 * lexp, "R6/R5 done timing", n, 20 * lexp);
        check(busy == 1'b0, "R6 busy low at done", int'(busy), 0);
        if (c[7]) exp_rdata = r;
        check(rdata == exp_rdata, "R4/R7 rdata", int'(rdata), int'(exp_rdata));
        @(posedge clk); #1;
        check(done == 1'b0, "R6 done one cycle", int'(done), 0);
        exp_sym[0] = 2;
        exp_sym[9] = 2;
        for (int i = 0; i < 8; i++) begin
            exp_sym[1+i]  = int'(c[i]);
            exp_sym[10+i] = c[7] ? int'(r[i]) : int'(w[i]);
        end
        sym_ok = (nsym == 18);
        bad_i = -1;
        if (sym_ok) begin
            for (int i = 0; i < 18; i++) begin
                if (sym[i] != exp_sym[i] && bad_i < 0) bad_i = i;
            end
        end
        check(nsym == 18, "R2 symbol count", nsym, 18);
        if (sym_ok)
            check(bad_i < 0, "R2/R3 wire symbols", (bad_i < 0) ? 0 : sym[bad_i],
                  (bad_i < 0) ? 0 : exp_sym[bad_i]);
        if (inject) check(err == 1'b1, "R8 err after start while busy", int'(err), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(busy == 0 && done == 0, "R1 reset busy/done", int'({busy, done}), 0);
        check(err == 0, "R1 reset err", int'(err), 0);
        check(line_oe == 0, "R1 reset line_oe", int'(line_oe), 0);
        check(rdata == 8'h00, "R1 reset rdata", int'(rdata), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R10 grant truth table while idle
        for (int s = 0; s < 2; s++) begin
            for (int t = 0; t < 2; t++) begin
                sw_en = s[0];
                tw_en = t[0];
                #1;
                check(tw_grant == (t[0] & ~s[0]), "R10 grant", int'(tw_grant), int'(t[0] & ~s[0]));
            end
        end

        // R9 start while disabled
        sw_en = 1'b0;
        tw_en = 1'b1;
        cmd = 8'h55;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (30) @(posedge clk);
        #1;
        check(busy == 1'b0, "R9 no launch when disabled", int'(busy), 0);
        check(nsym == 0, "R9 wire quiet when disabled", nsym, 0);
        check(err == 1'b0, "R9 no err when disabled", int'(err), 0);
        check(line_oe == 1'b0, "R1 idle line_oe", int'(line_oe), 0);
        sw_en = 1'b1;

        // R2 R3 R4 R6 R7 sweep every command at the minimum slot
        for (int i = 0; i < 256; i++) begin
            run_txn(8'(i), 8'((i * 37 + 5) & 255), 8'((i * 73 + 11) & 255), 8, 8, 1'b0);
        end

        // R5 slot lengths below the floor, odd lengths, and a mid-transfer change
        run_txn(8'hA5, 8'h00, 8'h6C, 0, 200, 1'b0);
        run_txn(8'h3C, 8'hF1, 8'h00, 5, 30, 1'b0);
        run_txn(8'hC3, 8'h00, 8'h9A, 9, 4, 1'b0);
        run_txn(8'h12, 8'h7E, 8'h00, 12, 8, 1'b0);
        run_txn(8'hFF, 8'h00, 8'h00, 23, 9, 1'b0);
        run_txn(8'h80, 8'h00, 8'hFF, 40, 0, 1'b0);

        // R8 start while busy
        check(err == 1'b0, "R8 err clear before", int'(err), 0);
        run_txn(8'h9B, 8'h00, 8'h3D, 8, 8, 1'b1);
        run_txn(8'h21, 8'hB4, 8'h00, 10, 10, 1'b0);
        check(err == 1'b1, "R8 err sticky", int'(err), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule